// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a synchronous on-chip requester read and write an external, clockless static RAM organised as 32K bytes. The requester offers one access at a time: a 15-bit address, a direction bit and, for stores, a byte of data. The block then walks the memory pins through a fixed series of phases (setup, strobe and recovery), each a whole number of clock cycles. Each phase length is worked out at elaboration time by rounding a nanosecond minimum up to whole clock periods.

Stores are framed by chip select and the write strobe both being low, with the output-enable pin held inactive for the whole store. The controller's own data driver is on only while the write strobe is low, so the memory's outputs and the controller's driver never overlap. Loads lower output enable after one setup phase and sample the memory bus on the last clock of the strobe phase. Every access is followed by a recovery phase with all strobes inactive.

Request side uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle, so a requester holding `req_valid` simply waits. The requester may change or withdraw an offer that has not been taken. Completion is reported by a one-cycle `rsp_valid` pulse. That response side has no back-pressure: the requester must be able to take it in the cycle it appears.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only when idle. It drops in the cycle after a request is taken and stays 0 until the access has finished recovery. With `req_valid` held high, stores are taken every SETUP+WRITE_STROBE+RECOVER+1 cycles (5 at the defaults).
- R3: A load from an address returns the byte most recently stored to that address, for every address bit and every data value.
- R4: During a store, `mem_we_n` is 0 for exactly ceil(max(write pulse, address-to-end, data setup) / clock period) cycles (2 at the defaults: 6.5 ns over 5 ns). `mem_ce_n` is 0 and `mem_oe_n` is 1 throughout those cycles.
- R5: `mem_dq_oe` (1 = controller drives `mem_dq_out`) is 1 only while `mem_we_n` and `mem_ce_n` are both 0.
- R6: `mem_ce_n` falls at least one cycle before `mem_we_n` or `mem_oe_n` falls. `mem_addr` equals the requested address and holds steady for as long as `mem_ce_n` is 0.
- R7: During a load, `mem_oe_n` is 0 for max(1, ceil(output-enable access / period), ceil(address access / period) − setup cycles) cycles (1 at the defaults). `mem_we_n` stays 1, and the bus is sampled at the last of those cycles.
- R8: `rsp_valid` is a single-cycle pulse in the cycle right after the strobe phase ends. That is cycle SETUP+WRITE_STROBE+1 after acceptance for a store (4 at the defaults) and SETUP+READ_STROBE+1 for a load (3). `rsp_rdata` carries the loaded byte while `rsp_valid` is high after a load.
- R9: `mem_oe_n` is never 0 while `mem_dq_oe` is 1 or was 1 in the previous cycle. Between two accesses `mem_ce_n` stays 1 for at least two cycles.
- R10: Store data on `mem_dq_out` is stable for at least the data-setup minimum (5 ns) before the edge that ends the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Loaded byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data seen on the memory bus |
| mem_dq_oe | output | 1 | Enable of the controller's bus driver |

## Verification
A byte sweep stores all 256 values at scattered addresses and reads them back, which separates data-path bit swaps and stuck bits from sequencing faults. A walking-one address pattern plus the all-zero and all-one addresses shows whether any address line is dropped or aliased. Back-to-back overwrites of one location, alternating with another, show that stores commit on the terminating edge and that loads sample after the access time and not before. A request held valid across several accesses exposes acceptance while busy or a missing recovery gap. Meanwhile a timing-aware memory model flags short data setup, strobe overlap and bus contention.

// File: rtl/sramc_pkg.sv
`timescale 1ns/100ps
package sramc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Memory-side control pins, active low except the driver enable.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin pattern held during a phase; only the strobe phase depends on direction.
  function automatic strobe_t strobe_for(input phase_e ph, input logic is_store);
    strobe_t s;
    s = STROBE_QUIET;
    case (ph)
      PH_SETUP: s.ce_n = 1'b0;
      PH_ACTIVE: begin
        s.ce_n = 1'b0;
        if (is_store) begin
          s.we_n = 1'b0;
          s.drv  = 1'b1;
        end else begin
          s.oe_n = 1'b0;
        end
      end
      default: s = STROBE_QUIET;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/100ps
module sramc_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_datapath.sv
`timescale 1ns/100ps
module sramc_datapath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic          op_store,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  // Operation fields are frozen at acceptance so the memory sees a stable
  // address and data for the whole access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_store <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      op_store <= req_we;
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/100ps
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_PS      = 5000,
  parameter int T_ASU_PS    = 0,     // address setup before strobe
  parameter int T_WPULSE_PS = 6500,  // write strobe width, output enable inactive
  parameter int T_AWE_PS    = 6500,  // address valid to write end
  parameter int T_DSU_PS    = 5000,  // data setup to write end
  parameter int T_ACC_PS    = 8000,  // address access
  parameter int T_OEACC_PS  = 4000,  // output-enable access
  parameter int T_RELEASE_PS= 4000,  // memory output release after deselect
  parameter int T_CYCLE_PS  = 8000   // minimum access cycle
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int SETUP_CYC = imax(1, cdiv(T_ASU_PS, CLK_PS));
  localparam int WR_CYC    = imax(1, cdiv(imax(T_WPULSE_PS, imax(T_AWE_PS, T_DSU_PS)), CLK_PS));
  localparam int RD_CYC    = imax(1, imax(cdiv(T_OEACC_PS, CLK_PS),
                                          cdiv(T_ACC_PS, CLK_PS) - SETUP_CYC));
  localparam int REC_CYC   = imax(imax(1, cdiv(T_RELEASE_PS, CLK_PS)),
                                  cdiv(T_CYCLE_PS, CLK_PS) - SETUP_CYC - imax(WR_CYC, RD_CYC));
  localparam int MAX_CYC   = imax(imax(SETUP_CYC, REC_CYC), imax(WR_CYC, RD_CYC));
  localparam int CW        = $clog2(MAX_CYC + 1);

  phase_e        ph_q, ph_d;
  logic          ph_done;
  logic          accept;
  logic          op_store;
  logic          load;
  logic [CW-1:0] load_val;
  logic          strobe_end;
  strobe_t       strb_q;
  logic          rsp_q;

  assign req_ready  = (ph_q == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign strobe_end = (ph_q == PH_ACTIVE) && ph_done;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:    if (req_valid) ph_d = PH_SETUP;
      PH_SETUP:   if (ph_done)   ph_d = PH_ACTIVE;
      PH_ACTIVE:  if (ph_done)   ph_d = PH_RECOVER;
      PH_RECOVER: if (ph_done)   ph_d = PH_IDLE;
      default:                   ph_d = PH_IDLE;
    endcase
  end

  assign load = (ph_d != ph_q);

  always_comb begin
    case (ph_d)
      PH_SETUP:   load_val = CW'(SETUP_CYC - 1);
      PH_ACTIVE:  load_val = op_store ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      PH_RECOVER: load_val = CW'(REC_CYC - 1);
      default:    load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      strb_q <= STROBE_QUIET;
      rsp_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      strb_q <= strobe_for(ph_d, op_store);
      rsp_q  <= strobe_end;
    end
  end

  sramc_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (ph_done)
  );

  sramc_datapath #(.AW(AW), .DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (strobe_end && !op_store),
    .bus_in    (mem_dq_in),
    .op_store  (op_store),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rsp_rdata)
  );

  assign mem_ce_n  = strb_q.ce_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_dq_oe = strb_q.drv;
  assign rsp_valid = rsp_q;

  // Acceptance closes the request side until recovery is over (R2).
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // The write strobe never overlaps output enable (R4).
  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // The driver is only on inside the store window (R5).
  p_drv_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  // A strobe falls only after chip select has been low a cycle (R6).
  p_setup_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) || $fell(mem_oe_n)) |-> $past(!mem_ce_n));

  // Address is frozen while the memory is selected (R6).
  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // Completion is a single-cycle pulse (R8).
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // Output enable waits a cycle after the driver lets go (R9).
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/100ps
module test_sram_async_ctrl;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int EXP_WR  = (6500 + 4999) / 5000;      // store strobe cycles
  localparam int EXP_RD  = (8000 + 4999) / 5000 - 1;  // load strobe cycles
  localparam int EXP_GAP = 1 + EXP_WR + 1 + 1;        // held-valid store spacing

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit rst_done = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] exp_mem [int];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] store [int];
  realtime t_addr = 0.0, t_oe = 0.0, t_data = 0.0, t_end = 0.0;
  wire wr_on = !mem_ce_n && !mem_we_n;

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(mem_dq_out or posedge mem_dq_oe) t_data = $realtime;
  always @(posedge mem_we_n or posedge mem_ce_n) t_end = $realtime;

  initial begin
    mem_dq_in = 'z;
    #0.25;
    forever begin
      if (rst_done && !mem_ce_n && mem_we_n && !mem_oe_n) begin
        if (mem_dq_oe) chk(1'b0, "R9 bus contention", 1, 0);
        if (($realtime - t_addr) >= 8.0 && ($realtime - t_oe) >= 4.0 &&
            store.exists(int'(mem_addr)))
          mem_dq_in = store[int'(mem_addr)];
        else
          mem_dq_in = 'x;
      end else begin
        mem_dq_in = mem_dq_oe ? mem_dq_out : 'z;
      end
      #0.5;
    end
  end

  // Store commit and pin-sequence monitor, sampled mid-cycle.
  logic          wr_prev = 1'b0, we_prev = 1'b1, oe_prev = 1'b1, ce_prev = 1'b1;
  logic [AW-1:0] wr_a;
  logic [DW-1:0] wr_d;
  bit            wr_drv_ok;
  int            we_run = 0, oe_run = 0, ce_lo = 0, ce_hi = 0;
  bit            seen_access = 1'b0;

  always @(negedge clk) begin
    if (rst_done) begin
      if (wr_on) begin
        if (!wr_prev) wr_drv_ok = 1'b1;
        wr_a = mem_addr;
        wr_d = mem_dq_out;
        if (!mem_dq_oe) wr_drv_ok = 1'b0;
      end
      if (wr_prev && !wr_on) begin
        chk(wr_drv_ok, "R5 driver on through store", 0, 1);
        chk((t_end - t_data) >= 5.0, "R10 data setup ns", int'(t_end - t_data), 5);
        store[int'(wr_a)] = wr_d;
      end
      if (mem_dq_oe && (mem_we_n || mem_ce_n)) chk(1'b0, "R5 driver outside store", 1, 0);
      if (!mem_we_n && !mem_oe_n) chk(1'b0, "R4 strobe overlap", 1, 0);
      if (!mem_ce_n) begin
        chk(mem_addr == cur_addr, "R6 address", int'(mem_addr), int'(cur_addr));
        ce_lo++;
      end
      if (!mem_we_n) we_run++;
      if (!mem_oe_n) oe_run++;
      if ((!mem_we_n && we_prev) || (!mem_oe_n && oe_prev))
        chk(ce_lo >= 2, "R6 setup before strobe", ce_lo, 2);
      if (mem_we_n && !we_prev) begin
        chk(we_run == EXP_WR, "R4 store strobe cycles", we_run, EXP_WR);
        we_run = 0;
      end
      if (mem_oe_n && !oe_prev) begin
        chk(oe_run == EXP_RD, "R7 load strobe cycles", oe_run, EXP_RD);
        oe_run = 0;
      end
      if (!mem_ce_n && ce_prev) begin
        if (seen_access) chk(ce_hi >= 2, "R9 deselect gap", ce_hi, 2);
        seen_access = 1'b1;
        ce_hi = 0;
      end
      if (mem_ce_n) begin
        ce_hi++;
        ce_lo = 0;
      end
      wr_prev = wr_on;
      we_prev = mem_we_n;
      oe_prev = mem_oe_n;
      ce_prev = mem_ce_n;
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cur_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(!req_ready, "R2 ready drops after accept", int'(req_ready), 0);
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
      if (!rsp_valid && req_ready) chk(1'b0, "R2 ready while busy", 1, 0);
    end
    chk(lat == (we ? 1 + EXP_WR + 1 : 1 + EXP_RD + 1), "R8 completion cycle", lat,
        we ? 1 + EXP_WR + 1 : 1 + EXP_RD + 1);
    q = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R8 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] q;
    access(1'b1, a, d, q);
    exp_mem[int'(a)] = d;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] q;
    access(1'b0, a, 8'h00, q);
    chk(q === exp_mem[int'(a)], req, int'(q), int'(exp_mem[int'(a)]));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: quiet pins under reset
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high",
        int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe, "R1 driver off", int'(mem_dq_oe), 0);
    chk(!rsp_valid && req_ready, "R1 rsp low ready high", int'({rsp_valid, req_ready}), 1);
    rst_n = 1'b1;
    rst_done = 1'b1;
    @(negedge clk);

    // R3: every byte value at scattered addresses
    for (int i = 0; i < 256; i++) wr(AW'((i * 97 + 3) & 16'h7fff), DW'(i));
    for (int i = 0; i < 256; i++) rd_chk(AW'((i * 97 + 3) & 16'h7fff), "R3 byte sweep");

    // R3: walking-one addresses plus both extremes, read back in reverse
    for (int b = 0; b < AW; b++) wr(AW'(1) << b, DW'(b * 17 + 1) ^ 8'hA5);
    wr('0, 8'hC3);
    wr('1, 8'h3C);
    rd_chk('1, "R3 top address");
    rd_chk('0, "R3 zero address");
    for (int b = AW - 1; b >= 0; b--) rd_chk(AW'(1) << b, "R3 address bit");

    // R3, R7: overwrite one location, interleaved with a neighbour
    for (int k = 0; k < 4; k++) begin
      wr(15'h2AAA, DW'(8'h55 << k));
      wr(15'h5555, DW'(~(8'h55 << k)));
      rd_chk(15'h2AAA, "R7 load after overwrite");
      rd_chk(15'h5555, "R7 load neighbour");
    end

    // R2: request held valid is taken once per completed store
    begin
      int first, second, cyc;
      first = -1; second = -1; cyc = 0;
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b1; req_addr = 15'h1234; req_wdata = 8'h5A;
      cur_addr = 15'h1234;
      for (int n = 0; n < 12; n++) begin
        if (req_ready) begin
          if (first < 0) first = cyc;
          else if (second < 0) second = cyc;
        end
        @(negedge clk);
        cyc++;
      end
      req_valid = 1'b0;
      exp_mem[int'(15'h1234)] = 8'h5A;
      chk(second - first == EXP_GAP, "R2 held-valid spacing", second - first, EXP_GAP);
      repeat (10) @(negedge clk);
      rd_chk(15'h1234, "R3 held-valid store");
    end

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule